// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading up to two 32-bit descriptors from memory. A requester supplies the virtual address and a 16 KB aligned first-level table base. The walker then issues word reads on a valid/ready memory port. The first-level entry can describe a 1 MB section directly, or it can point to a second-level table. A second-level entry describes a 64 KB large page or a 4 KB small page. The page size is chosen from the descriptor type bits at each level.

When the walk ends on a leaf whose access flag is clear, the walker sets that flag in its copy of the descriptor. It writes the modified word back to the same address before it presents the result. The result gives the physical address, the mapping size, the access permissions, the execute-never and global flags, the memory attribute bits, and a fault code with the level at which the fault arose.

Only one walk is in flight at a time. A new request is not accepted until the result has been taken with `res_ready`.

Top module: `pt_walker`

## Requirements
- R1: After a request is accepted, the first memory access is a read at {base[31:14], va[31:20], 2'b00}.
- R2: A first-level type of 0 or 3 (descriptor bits [1:0]) ends the walk after one read with fault code 1 (translation) and fault level 0. No write is made. On any fault, res_pa, res_ap, res_attr, res_xn and res_global are zero.
- R3: A first-level type of 2 with bit 18 clear is a section. res_pa = {desc[31:20], va[19:0]}, res_size = 0, and only one read is made.
- R4: A first-level type of 2 with bit 18 set ends the walk with fault code 2 (unsupported size) at fault level 0, with no write.
- R5: A first-level type of 1 causes a second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level descriptor with bits [1:0] == 0 ends the walk with fault code 1 at fault level 1.
- R7: A second-level descriptor with bit 1 clear and bit 0 set is a large page: res_pa = {desc[31:16], va[15:0]}, res_size = 1. One with bit 1 set is a small page: res_pa = {desc[31:12], va[11:0]}, res_size = 2.
- R8: res_xn is descriptor bit 4 for a section, bit 15 for a large page and bit 0 for a small page.
- R9: res_ap is {b15, b11, b10} for a section and {b9, b5, b4} for a page. res_global is the inverse of bit 17 for a section and the inverse of bit 11 for a page. Both are taken from the descriptor after the access flag has been set.
- R10: res_attr is {b14:b12, b3, b2} for a section and a large page, and {b8:b6, b3, b2} for a small page.
- R11: If the leaf's access flag (bit 10 for a section, bit 4 for a page) is clear, exactly one write of the descriptor with that bit set is made to the leaf's address before res_valid rises. If the flag is already set, no write is made.
- R12: req_ready is low from acceptance until the result handshake. While res_ready is low, res_valid and all result fields hold.
- R13: While mem_req_ready is low, mem_req_valid, mem_req_addr and mem_req_write hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base, 16 KB aligned |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_req_write | output | 1 | 1 = write-back, 0 = descriptor read |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken |
| res_pa | output | 32 | Physical address |
| res_size | output | 2 | 0 section, 1 large page, 2 small page |
| res_ap | output | 3 | Access permission bits |
| res_xn | output | 1 | Execute-never |
| res_global | output | 1 | Mapping is global |
| res_attr | output | 5 | Memory attribute bits |
| res_fault | output | 2 | 0 none, 1 translation, 2 unsupported size |
| res_fault_lvl | output | 1 | 0 first level, 1 second level |

## Verification
The bench aims at the places where the two levels differ. It checks that the execute-never, permission and attribute fields move between a section, a large page and a small page. A design that shared one bit map across the levels would report wrong permissions for pages. It checks that a clear access flag produces exactly one write of the corrected word at the leaf address, and that a flag already set produces none. A walker that always wrote, or that wrote to the first-level address after a second-level leaf, would corrupt memory. Reserved and ignore types, supersections and invalid second-level entries are each driven to check the fault code and level, and a stalling memory port checks that the request is held.

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] req_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_pa,
  output logic [1:0]  res_size,
  output logic [2:0]  res_ap,
  output logic        res_xn,
  output logic        res_global,
  output logic [4:0]  res_attr,
  output logic [1:0]  res_fault,
  output logic        res_fault_lvl
);
  localparam logic [1:0] SZ_SECTION = 2'd0;
  localparam logic [1:0] SZ_LARGE   = 2'd1;
  localparam logic [1:0] SZ_SMALL   = 2'd2;
  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_XLAT   = 2'd1;
  localparam logic [1:0] FLT_SIZE   = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_WB, S_DONE
  } state_t;

  state_t      st;
  logic [31:0] va_q, addr_q, desc_q;
  logic [1:0]  size_q, fault_q;
  logic        lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      desc_q  <= '0;
      size_q  <= SZ_SECTION;
      fault_q <= FLT_NONE;
      lvl_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_va;
          addr_q  <= {req_base[31:14], req_va[31:20], 2'b00};
          fault_q <= FLT_NONE;
          lvl_q   <= 1'b0;
          size_q  <= SZ_SECTION;
          desc_q  <= '0;
          st      <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_rdata;
          case (mem_rsp_rdata[1:0])
            2'd1: begin
              addr_q <= {mem_rsp_rdata[31:10], va_q[19:12], 2'b00};
              st     <= S_L2_REQ;
            end
            2'd2: begin
              size_q <= SZ_SECTION;
              if (mem_rsp_rdata[18]) begin
                fault_q <= FLT_SIZE;
                st      <= S_DONE;
              end else if (!mem_rsp_rdata[10]) begin
                desc_q <= mem_rsp_rdata | 32'h0000_0400;
                st     <= S_WB;
              end else begin
                st <= S_DONE;
              end
            end
            default: begin
              fault_q <= FLT_XLAT;
              st      <= S_DONE;
            end
          endcase
        end
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_rdata;
          lvl_q  <= 1'b1;
          if (mem_rsp_rdata[1:0] == 2'd0) begin
            fault_q <= FLT_XLAT;
            st      <= S_DONE;
          end else begin
            size_q <= mem_rsp_rdata[1] ? SZ_SMALL : SZ_LARGE;
            if (!mem_rsp_rdata[4]) begin
              desc_q <= mem_rsp_rdata | 32'h0000_0010;
              st     <= S_WB;
            end else begin
              st <= S_DONE;
            end
          end
        end
        S_WB:   if (mem_req_ready) st <= S_DONE;
        S_DONE: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ) || (st == S_WB);
  assign mem_req_write = (st == S_WB);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = (st == S_WB) ? desc_q : 32'h0;
  assign res_valid     = (st == S_DONE);
  assign res_fault     = fault_q;
  assign res_fault_lvl = lvl_q;
  assign res_size      = size_q;

  wire ok = (fault_q == FLT_NONE);
  wire is_sec = (size_q == SZ_SECTION);

  logic [31:0] pa_c;
  logic        xn_c;
  always_comb begin
    case (size_q)
      SZ_LARGE: begin pa_c = {desc_q[31:16], va_q[15:0]}; xn_c = desc_q[15]; end
      SZ_SMALL: begin pa_c = {desc_q[31:12], va_q[11:0]}; xn_c = desc_q[0];  end
      default:  begin pa_c = {desc_q[31:20], va_q[19:0]}; xn_c = desc_q[4];  end
    endcase
  end

  assign res_pa     = ok ? pa_c : 32'h0;
  assign res_xn     = ok & xn_c;
  assign res_ap     = !ok ? 3'b000 :
                      is_sec ? {desc_q[15], desc_q[11:10]} : {desc_q[9], desc_q[5:4]};
  assign res_global = ok & (is_sec ? ~desc_q[17] : ~desc_q[11]);
  assign res_attr   = !ok ? 5'b0 :
                      (size_q == SZ_SMALL) ? {desc_q[8:6], desc_q[3:2]}
                                           : {desc_q[14:12], desc_q[3:2]};
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_pa,
  input logic [1:0]  res_size,
  input logic [2:0]  res_ap,
  input logic [1:0]  res_fault
);
  logic        busy;
  logic [31:0] cap_va;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cap_va <= '0;
    end else begin
      if (req_valid && req_ready) begin
        busy   <= 1'b1;
        cap_va <= req_va;
      end else if (res_valid && res_ready) begin
        busy <= 1'b0;
      end
    end
  end

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R12
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_fault) && $stable(res_ap)); // R12
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R13
  AST_SECTION_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 && res_size == 2'd0 |-> res_pa[19:0] == cap_va[19:0]); // R3
  AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 && res_size == 2'd2 |-> res_pa[11:0] == cap_va[11:0]); // R7
  AST_WB_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> (mem_req_wdata[10] || mem_req_wdata[4])); // R11
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'd0 |-> res_pa == 32'h0 && res_ap == 3'b000); // R2
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .res_valid(res_valid), .res_ready(res_ready),
  .res_pa(res_pa), .res_size(res_size), .res_ap(res_ap), .res_fault(res_fault)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, res_ready = 1'b0;
  logic [31:0] req_va = '0, req_base = '0;
  logic        req_ready, mem_req_valid, mem_req_write, res_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata, res_pa;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic [1:0]  res_size, res_fault;
  logic [2:0]  res_ap;
  logic        res_xn, res_global, res_fault_lvl;
  logic [4:0]  res_attr;

  pt_walker u_dut (.*);

  int checks = 0, errors = 0;
  logic [31:0] mem [int unsigned];
  logic stall = 1'b0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_prev = '0, rd_last = '0, wr_addr = '0, wr_data = '0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_req_addr;
        wr_data <= mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
        rd_cnt  <= rd_cnt + 1;
        rd_prev <= rd_last;
        rd_last <= mem_req_addr;
      end
    end
    mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  int rd0, wr0;
  logic [31:0] o_pa; logic [1:0] o_size, o_fault; logic [2:0] o_ap;
  logic o_xn, o_gl, o_lvl; logic [4:0] o_attr;

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input int hold);
    int guard;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!res_valid && guard < 1000) begin @(negedge clk); guard++; end
    if (guard >= 1000) begin errors++; $display("FAIL R12: walk timeout actual 0 expected 1"); end
    o_pa = res_pa; o_size = res_size; o_fault = res_fault; o_ap = res_ap;
    o_xn = res_xn; o_gl = res_global; o_lvl = res_fault_lvl; o_attr = res_attr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R12 res_valid held", {31'b0, res_valid}, 32'd1);
      chk("R12 pa held", res_pa, o_pa);
      chk("R12 req_ready low", {31'b0, req_ready}, 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_reset;
    chk("R12 reset req_ready", {31'b0, req_ready}, 32'd1);
    chk("R12 reset res_valid", {31'b0, res_valid}, 32'd0);
    chk("R13 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic test_section_af;
    mem[32'h0010_048C] = 32'hABC0_D81A;
    walk(32'h1234_5678, 32'h0010_0000, 3);
    chk("R1 l1 addr", rd_last, 32'h0010_048C);
    chk("R3 reads", rd_cnt - rd0, 1);
    chk("R3 pa", o_pa, 32'hABC4_5678);
    chk("R3 size", {30'b0, o_size}, 0);
    chk("R8 xn section", {31'b0, o_xn}, 1);
    chk("R9 ap section", {29'b0, o_ap}, 7);
    chk("R9 global section", {31'b0, o_gl}, 1);
    chk("R10 attr section", {27'b0, o_attr}, 32'h16);
    chk("R11 writes", wr_cnt - wr0, 1);
    chk("R11 wb addr", wr_addr, 32'h0010_048C);
    chk("R11 wb data", wr_data, 32'hABC0_DC1A);
  endtask

  task automatic test_section_stall;
    stall = 1'b1;
    mem[32'h0010_0000] = 32'h0072_0402;
    walk(32'h0000_0ABC, 32'h0010_0000, 0);
    stall = 1'b0;
    chk("R13 l1 addr stalled", rd_last, 32'h0010_0000);
    chk("R3 pa stalled", o_pa, 32'h0070_0ABC);
    chk("R9 ap flag set", {29'b0, o_ap}, 1);
    chk("R9 not global", {31'b0, o_gl}, 0);
    chk("R8 xn clear", {31'b0, o_xn}, 0);
    chk("R11 no write", wr_cnt - wr0, 0);
  endtask

  task automatic test_l1_faults;
    mem[32'h0010_3FFC] = 32'h0;
    walk(32'hFFF0_0000, 32'h0010_0000, 0);
    chk("R2 type0 fault", {30'b0, o_fault}, 1);
    chk("R2 type0 lvl", {31'b0, o_lvl}, 0);
    chk("R2 type0 reads", rd_cnt - rd0, 1);
    chk("R2 type0 pa", o_pa, 0);
    mem[32'h0010_0004] = 32'hFFFF_FFFF;
    walk(32'h0010_0000, 32'h0010_0000, 0);
    chk("R2 type3 fault", {30'b0, o_fault}, 1);
    chk("R2 type3 writes", wr_cnt - wr0, 0);
    chk("R2 type3 ap", {29'b0, o_ap}, 0);
    chk("R2 type3 attr", {27'b0, o_attr}, 0);
  endtask

  task automatic test_supersection;
    mem[32'h0010_0008] = 32'h0004_0002;
    walk(32'h0020_0000, 32'h0010_0000, 0);
    chk("R4 fault", {30'b0, o_fault}, 2);
    chk("R4 lvl", {31'b0, o_lvl}, 0);
    chk("R4 writes", wr_cnt - wr0, 0);
  endtask

  task automatic test_small;
    mem[32'h0010_000C] = 32'h0020_0401;
    mem[32'h0020_0414] = 32'h7654_32EF;
    walk(32'h0030_5ABC, 32'h0010_0000, 1);
    chk("R5 reads", rd_cnt - rd0, 2);
    chk("R5 l2 addr", rd_last, 32'h0020_0414);
    chk("R1 l1 addr small", rd_prev, 32'h0010_000C);
    chk("R7 small pa", o_pa, 32'h7654_3ABC);
    chk("R7 small size", {30'b0, o_size}, 2);
    chk("R8 xn small", {31'b0, o_xn}, 1);
    chk("R9 ap small", {29'b0, o_ap}, 7);
    chk("R9 global small", {31'b0, o_gl}, 1);
    chk("R10 attr small", {27'b0, o_attr}, 32'h0F);
    chk("R11 l2 wb addr", wr_addr, 32'h0020_0414);
    chk("R11 l2 wb data", wr_data, 32'h7654_32FF);
    chk("R11 l2 writes", wr_cnt - wr0, 1);
  endtask

  task automatic test_large;
    mem[32'h0010_0010] = 32'h0030_0001;
    mem[32'h0030_0020] = 32'h1111_A815;
    walk(32'h0040_8765, 32'h0010_0000, 0);
    chk("R5 large l2 addr", rd_last, 32'h0030_0020);
    chk("R7 large pa", o_pa, 32'h1111_8765);
    chk("R7 large size", {30'b0, o_size}, 1);
    chk("R8 xn large", {31'b0, o_xn}, 1);
    chk("R9 ap large", {29'b0, o_ap}, 1);
    chk("R9 global large", {31'b0, o_gl}, 0);
    chk("R10 attr large", {27'b0, o_attr}, 32'h09);
    chk("R11 large no write", wr_cnt - wr0, 0);
  endtask

  task automatic test_l2_invalid;
    mem[32'h0010_0014] = 32'h0040_0001;
    mem[32'h0040_0004] = 32'h0;
    walk(32'h0050_1000, 32'h0010_0000, 0);
    chk("R6 fault", {30'b0, o_fault}, 1);
    chk("R6 lvl", {31'b0, o_lvl}, 1);
    chk("R6 reads", rd_cnt - rd0, 2);
    chk("R6 writes", wr_cnt - wr0, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_section_af();
    test_section_stall();
    test_l1_faults();
    test_supersection();
    test_small();
    test_large();
    test_l2_invalid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule